// File: doc/BRIEF.md
# MDIO Management Access Unit

This block is a management-interface master for Ethernet PHYs. A host drives one 32-bit access word into the unit: a command/busy flag, a read/write select, a 5-bit PHY address, a 5-bit register address and 16 data bits. When the command flag is written as 1 and the unit is idle, it sends one clause-22 management frame on the MDC/MDIO pins. On a read it releases the data line for the turnaround and data bits, and it shifts in the 16 bits the PHY returns.

The same access word can be read back at all times. Bit 31 reads 1 for the length of the frame. When the frame ends, bit 31 clears and, after a read, the low half holds the PHY's data. MDC comes from the system clock through an even divider set by a parameter. MDIO leaves the block as a data bit plus an output enable, so the pad tristate sits outside the block.

Top module: `mdio_access_unit`

## Requirements
- R1: A write with bit 31 set while idle starts a frame. Bit 31 of the readback reads 1 from the next cycle for exactly 64*CLK_DIV cycles, then reads 0.
- R2: The 64 bits of each frame, MSB first, are:
  - 32 ones,
  - the start code 01,
  - the opcode (10 when bit 30 is 1 for a read, 01 when bit 30 is 0 for a write),
  - the PHY address from bits 25:21,
  - the register address from bits 20:16.
- R3: A write frame continues with turnaround 10 and then the data from bits 15:0, MSB first. The output enable is high for all 64 bits.
- R4: A read frame drops the output enable from bit 46 (the first turnaround bit) to the end of the frame. The unit samples MDIO at the MDC rising edges of bits 48..63, MSB first. At completion it places the 16 sampled bits in bits 15:0.
- R5: MDC idles low and starts each frame low. While busy it has a period of CLK_DIV system clocks at 50% duty. The MDIO output changes only on MDC falling edges.
- R6: While idle, MDC is 0 and the MDIO output enable is 0.
- R7: A write arriving while busy is ignored. The stored fields and the frame in progress are unchanged.
- R8: A write with bit 31 clear is ignored. No frame starts and the readback word is unchanged.
- R9: After reset, the readback word is 0, MDC is 0 and the output enable is 0.
- R10: Bits 29:26 of the readback word always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_wr_en | input | 1 | Write strobe for the access word |
| acc_wr_data | input | 32 | Access word being written |
| acc_word | output | 32 | Access word readback: busy, op, addresses, data |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for the MDIO pad |
| mdio_i | input | 1 | Management data from the pad |

## Verification
A wrong bit counter or a wrong divider shows up within one frame in two ways. The busy readback lasts a different number of cycles than 64*CLK_DIV. The number and spacing of MDC rising edges are off. A fault in the frame shift register or the opcode/address packing corrupts a specific frame bit seen at an MDC rising edge. A fault in the enable release or the input shift corrupts the read value placed in the low half of the word at the end of the frame. A busy gate that is missing or wrong shows up the cycle after a stray write: the readback fields change, or MDC toggles while idle.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int WORD_W     = 32;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + 2 + 2 + ADDR_W + ADDR_W + 2 + DATA_W;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  // first bit index where a read frame releases the line (turnaround)
  localparam int TA_IDX     = PRE_BITS + 4 + 2 * ADDR_W;
  // first bit index of the data field
  localparam int DATA_IDX   = TA_IDX + 2;

  // access word field positions
  localparam int CMD_BIT  = 31;
  localparam int OP_BIT   = 30;
  localparam int PHY_LSB  = 21;
  localparam int REG_LSB  = 16;

  typedef struct packed {
    logic              is_read;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic [DATA_W-1:0] data;
  } mdio_req_t;

  function automatic logic [FRAME_BITS-1:0] pack_frame(input mdio_req_t r);
    logic [1:0] op;
    op = r.is_read ? 2'b10 : 2'b01;
    return {{PRE_BITS{1'b1}}, 2'b01, op, r.phy, r.regad, 2'b10, r.data};
  endfunction
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int CLK_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          wrap;

  assign wrap = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = wrap && !mdc_q;
  assign fall_tick = wrap &&  mdc_q;
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mdio_req_t         req,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              done_read,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] TA_POS   = BIT_W'(TA_IDX);
  localparam logic [BIT_W-1:0] DAT_POS  = BIT_W'(DATA_IDX);

  logic [FRAME_BITS-1:0] frame_q, frame_d;
  logic [BIT_W-1:0]      bit_q, bit_d;
  logic                  act_q, act_d;
  logic                  rd_q, rd_d;
  logic [DATA_W-1:0]     sin_q, sin_d;
  logic                  last_fall;

  assign last_fall = act_q && fall_tick && (bit_q == LAST_BIT);

  always_comb begin
    frame_d = frame_q;
    bit_d   = bit_q;
    act_d   = act_q;
    rd_d    = rd_q;
    sin_d   = sin_q;
    if (start && !act_q) begin
      frame_d = pack_frame(req);
      bit_d   = '0;
      act_d   = 1'b1;
      rd_d    = req.is_read;
    end else if (act_q) begin
      if (rise_tick && rd_q && (bit_q >= DAT_POS))
        sin_d = {sin_q[DATA_W-2:0], mdio_i};
      if (fall_tick) begin
        if (bit_q == LAST_BIT) begin
          act_d = 1'b0;
        end else begin
          frame_d = {frame_q[FRAME_BITS-2:0], 1'b0};
          bit_d   = bit_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      bit_q   <= '0;
      act_q   <= 1'b0;
      rd_q    <= 1'b0;
      sin_q   <= '0;
    end else begin
      frame_q <= frame_d;
      bit_q   <= bit_d;
      act_q   <= act_d;
      rd_q    <= rd_d;
      sin_q   <= sin_d;
    end
  end

  assign busy      = act_q;
  assign done      = last_fall;
  assign done_read = last_fall && rd_q;
  assign mdio_o    = act_q ? frame_q[FRAME_BITS-1] : 1'b0;
  assign mdio_oe   = act_q && !(rd_q && (bit_q >= TA_POS));
  assign rdata     = sin_q;
endmodule

// File: rtl/mdio_acc_reg.sv
module mdio_acc_reg
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              busy,
  input  logic              done_read,
  input  logic [DATA_W-1:0] rdata,
  output logic              start,
  output mdio_req_t         req,
  output logic [WORD_W-1:0] word
);
  mdio_req_t req_q, req_d;
  logic      accept;

  assign accept = wr_en && wr_data[CMD_BIT] && !busy;

  always_comb begin
    req_d = req_q;
    if (accept) begin
      req_d.is_read = wr_data[OP_BIT];
      req_d.phy     = wr_data[PHY_LSB +: ADDR_W];
      req_d.regad   = wr_data[REG_LSB +: ADDR_W];
      req_d.data    = wr_data[DATA_W-1:0];
    end else if (done_read) begin
      req_d.data    = rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end

  // start launches from the incoming word so the frame begins this edge
  assign start         = accept;
  assign req.is_read   = wr_data[OP_BIT];
  assign req.phy       = wr_data[PHY_LSB +: ADDR_W];
  assign req.regad     = wr_data[REG_LSB +: ADDR_W];
  assign req.data      = wr_data[DATA_W-1:0];
  assign word = {busy, req_q.is_read, 4'b0000, req_q.phy, req_q.regad, req_q.data};
endmodule

// File: rtl/mdio_access_unit.sv
module mdio_access_unit
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_wr_en,
  input  logic [31:0] acc_wr_data,
  output logic [31:0] acc_word,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic              rst_s1, rst_s2;
  logic              start, busy, done, done_read;
  logic              rise_tick, fall_tick;
  logic [DATA_W-1:0] rdata;
  mdio_req_t         req;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  mdio_acc_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_s2),
    .wr_en     (acc_wr_en),
    .wr_data   (acc_wr_data),
    .busy      (busy),
    .done_read (done_read),
    .rdata     (rdata),
    .start     (start),
    .req       (req),
    .word      (acc_word)
  );

  mdio_clk_gen #(.CLK_DIV(CLK_DIV)) u_clk (
    .clk       (clk),
    .rst_n     (rst_s2),
    .run       (busy),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_s2),
    .start     (start),
    .req       (req),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .busy      (busy),
    .done      (done),
    .done_read (done_read),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .rdata     (rdata)
  );
endmodule

// File: rtl/mdio_access_unit_chk.sv
module mdio_access_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_wr_en,
  input logic [31:0] acc_wr_data,
  input logic [31:0] acc_word,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  // R6
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_word[31] |-> (!mdc && !mdio_oe));

  // R1
  start_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_word[31]) |-> $past(acc_wr_en && acc_wr_data[31]));

  // R7
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_word[31] && $past(acc_word[31])) |-> $stable(acc_word[30:0]));

  // R5
  mdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_word[31] && $past(acc_word[31]) && !$stable(mdio_o)) |-> $fell(mdc));

  // R10
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_word[29:26] == 4'b0000);

  // R8
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(acc_word[31]) && !$past(acc_wr_en && acc_wr_data[31])) |-> !acc_word[31]);
endmodule

bind mdio_access_unit mdio_access_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_wr_en   (acc_wr_en),
  .acc_wr_data (acc_wr_data),
  .acc_word    (acc_word),
  .mdc         (mdc),
  .mdio_o      (mdio_o),
  .mdio_oe     (mdio_oe)
);

// File: tb/tb_mdio_access_unit.sv
`timescale 1ns/1ps
module tb_mdio_access_unit;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_wr_en;
  logic [31:0] acc_wr_data;
  logic [31:0] acc_word;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [63:0] mon_bits, mon_oe;
  int          mon_cnt, fall_cnt, last_rise, per_bad;
  logic        phy_rd;
  logic [15:0] phy_data;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  mdio_access_unit #(.CLK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .acc_wr_en(acc_wr_en), .acc_wr_data(acc_wr_data),
    .acc_word(acc_word), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge mdc) begin
    #1;
    if (mon_cnt > 0 && (cyc - last_rise) != DIV) per_bad++;
    last_rise = cyc;
    mon_bits  = {mon_bits[62:0], mdio_o};
    mon_oe    = {mon_oe[62:0], mdio_oe};
    mon_cnt++;
  end

  always @(negedge mdc) begin
    fall_cnt++;
    if (phy_rd && fall_cnt >= 48 && fall_cnt <= 63) mdio_i = phy_data[63-fall_cnt];
    else mdio_i = 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wdat, input logic [15:0] pdat, input logic inject);
    logic [63:0] exp_f, exp_oe;
    int busy_cnt;
    mon_cnt = 0; fall_cnt = 0; per_bad = 0; mon_bits = '0; mon_oe = '0;
    phy_rd = rd; phy_data = pdat;
    @(negedge clk);
    acc_wr_en = 1'b1;
    acc_wr_data = {1'b1, rd, 4'b1111, phy, rg, wdat};
    @(negedge clk);
    acc_wr_en = 1'b0;
    busy_cnt = 0;
    while (acc_word[31] && busy_cnt < 5000) begin
      busy_cnt++;
      if (inject && busy_cnt == 100) begin
        acc_wr_en = 1'b1;
        acc_wr_data = {1'b1, ~rd, 4'b0, ~phy, ~rg, ~wdat};
      end else acc_wr_en = 1'b0;
      @(negedge clk);
    end
    acc_wr_en = 1'b0;
    exp_f  = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, wdat};
    exp_oe = rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
    // R1 busy length
    chk("R1", 64'(busy_cnt), 64'(64 * DIV));
    // R5 rising edge count and period
    chk("R5", {32'(mon_cnt), 32'(per_bad)}, {32'd64, 32'd0});
    // R2 header bits / R3 write body
    chk(rd ? "R2" : "R3", mon_bits & exp_oe, exp_f & exp_oe);
    // R3/R4 enable pattern
    chk(rd ? "R4" : "R3", mon_oe, exp_oe);
    // R4 capture, R7 fields kept, R10 spare bits
    chk(rd ? "R4" : (inject ? "R7" : "R10"), 64'(acc_word),
        64'({1'b0, rd, 4'b0, phy, rg, (rd ? pdat : wdat)}));
    // R6 idle pins
    chk("R6", {62'b0, mdc, mdio_oe}, 64'b0);
  endtask

  initial begin
    rst_n = 1'b0; acc_wr_en = 1'b0; acc_wr_data = '0; mdio_i = 1'b1;
    phy_rd = 1'b0; phy_data = '0; mon_cnt = 0; fall_cnt = 0; per_bad = 0; last_rise = 0;
    mon_bits = '0; mon_oe = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", {acc_word, 30'b0, mdc, mdio_oe}, 64'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9", {acc_word, 30'b0, mdc, mdio_oe}, 64'b0);

    for (int p = 0; p < 32; p++) begin
      run_frame(1'b0, 5'(p), 5'(31 - p), 16'(p * 16'h0841 ^ 16'hA5C3), 16'h0, 1'b0);
      run_frame(1'b1, 5'(p), 5'(p ^ 5'h15), 16'h1234, 16'(p * 16'h1357 ^ 16'h8E01), 1'b0);
    end
    run_frame(1'b0, 5'h1F, 5'h00, 16'hFFFF, 16'h0, 1'b0);
    run_frame(1'b1, 5'h00, 5'h1F, 16'h0000, 16'h0000, 1'b0);
    run_frame(1'b1, 5'h1F, 5'h1F, 16'h0000, 16'hFFFF, 1'b0);
    // R7 write during busy
    run_frame(1'b0, 5'h0A, 5'h05, 16'hC0DE, 16'h0, 1'b1);
    run_frame(1'b1, 5'h03, 5'h11, 16'h0000, 16'hBEEF, 1'b1);

    // R8 write with command bit clear
    mon_cnt = 0;
    @(negedge clk);
    acc_wr_en = 1'b1;
    acc_wr_data = 32'h7FFF_FFFF;
    @(negedge clk);
    acc_wr_en = 1'b0;
    repeat (20) @(negedge clk);
    chk("R8", {acc_word, 32'(mon_cnt)},
        {1'b0, 1'b1, 4'b0, 5'h03, 5'h11, 16'hBEEF, 32'd0});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule